// File: doc/BRIEF.md
# Misaligned Access Splitter

This block stands between a load/store unit and a memory bus that only carries naturally aligned transfers. It accepts one operand request at a time. Each request carries an address, a size code (byte, word or long), a direction and, for stores, the write data. A request that is already aligned goes out as a single bus transfer. A misaligned word or long is broken into a short sequence of aligned byte and word transfers, and the low address bits choose that sequence. The block issues the transfers one after another over a valid/ready handshake.

Operands are big-endian. The first sub-transfer, at the lowest address, carries the most significant bytes. Each later piece starts at the byte right after the ones already moved. On reads, the returned pieces are shifted in from the most significant end to rebuild the operand. When the last transfer completes, the block raises a single-cycle done pulse. In that same cycle it presents the merged read value and the number of bus reads and writes used. It can accept the next request in that done cycle.

Top module: `misalign_splitter`

## Requirements
- R1: A byte request at any address, a word request with address bit 0 clear, and a long request with address bits [1:0] = 00 each use exactly one bus transfer. That transfer has the request's own size code and the request address.
- R2: A word request with address bit 0 set is issued as two byte transfers, at A and then at A+1.
- R3: A long request with address bit 0 set is issued as three transfers: a byte at A, a word at A+1, and a byte at A+3.
- R4: A long request with address bits [1:0] = 10 is issued as two word transfers, at A and then at A+2.
- R5: Every bus transfer is naturally aligned. A word transfer has bus_addr[0] = 0, and a long transfer has bus_addr[1:0] = 00. Size codes are 0 = byte, 1 = word, 2 = long.
- R6: For stores, each piece's bytes are right-aligned in bus_wdata, and the bits above the piece are zero. The first piece carries the most significant bytes of the operand, which is itself right-aligned in req_wdata.
- R7: For loads, each piece is taken from the low bytes of bus_rdata, and the bits above it are ignored. In the done cycle, rdata holds the merged operand, right-aligned and zero-extended, with the first piece in its most significant bytes.
- R8: In the done cycle, rd_count holds the number of bus transfers for a load and wr_count holds it for a store. The other count is zero.
- R9: While bus_valid is high and bus_ready is low, bus_valid, bus_addr, bus_size and bus_wdata stay unchanged. The next piece appears only after a cycle with both bus_valid and bus_ready high.
- R10: req_ready is high only when no request is in progress. A request is taken when req_valid and req_ready are both high. Request inputs presented while the block is busy have no effect. done is a one-cycle pulse in the cycle after the final handshake, and a new request may be accepted in that cycle.
- R11: During reset, and after reset release, bus_valid and done are low and req_ready is high. rst_n is asserted asynchronously and released through a two-flop synchronizer.
- R12: Size code 3 is treated as a byte request: one byte transfer at the request address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | AW | Operand byte address |
| req_size | input | 2 | Operand size code (0 byte, 1 word, 2 long, 3 treated as byte) |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 32 | Store operand, right-aligned |
| bus_valid | output | 1 | Sub-transfer valid |
| bus_ready | input | 1 | Bus accepts the sub-transfer |
| bus_addr | output | AW | Sub-transfer address |
| bus_size | output | 2 | Sub-transfer size code |
| bus_write | output | 1 | Sub-transfer direction |
| bus_wdata | output | 32 | Sub-transfer store data, right-aligned |
| bus_rdata | input | 32 | Sub-transfer load data, right-aligned, sampled on handshake |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Merged load operand, valid with done |
| rd_count | output | 2 | Bus reads used, valid with done |
| wr_count | output | 2 | Bus writes used, valid with done |

## Verification
The completion of one request and the acceptance of the next can fall in the same cycle. In that done cycle, req_ready is already high while rdata and the counts still describe the finished request. The bench walks its vector table back to back. Each request is driven in the done cycle of the one before, so every vector checks, at that edge, both the old request's merged value and counts and the new request's first transfer one cycle later. A separate run holds a conflicting request on the inputs for the whole sequence, and the bench confirms that it neither changes the pieces issued nor is taken early.

// File: rtl/mas_pkg.sv
package mas_pkg;
  localparam int DW = 32;
  localparam int BW = $clog2(DW / 8) + 1;
  localparam int MAX_PIECES = 3;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] SZ_LONG = 2'd2;

  typedef struct packed {
    logic [1:0]                  count;
    logic [MAX_PIECES-1:0][1:0]  psz;
  } plan_t;

  function automatic logic [BW-1:0] size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_WORD: size_bytes = BW'(2);
      SZ_LONG: size_bytes = BW'(4);
      default: size_bytes = BW'(1);
    endcase
  endfunction

  function automatic logic [1:0] pick_size(input plan_t p, input logic [1:0] idx);
    case (idx)
      2'd0:    pick_size = p.psz[0];
      2'd1:    pick_size = p.psz[1];
      default: pick_size = p.psz[2];
    endcase
  endfunction
endpackage

// File: rtl/mas_rst_sync.sv
module mas_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/mas_planner.sv
module mas_planner
  import mas_pkg::*;
(
  input  logic [1:0] addr_lo,
  input  logic [1:0] size,
  output plan_t      plan
);
  always_comb begin
    plan        = '0;
    plan.count  = 2'd1;
    plan.psz[0] = SZ_BYTE;
    case (size)
      SZ_WORD: begin
        if (addr_lo[0]) begin
          plan.count  = 2'd2;
          plan.psz[0] = SZ_BYTE;
          plan.psz[1] = SZ_BYTE;
        end else begin
          plan.psz[0] = SZ_WORD;
        end
      end
      SZ_LONG: begin
        if (addr_lo[0]) begin
          plan.count  = 2'd3;
          plan.psz[0] = SZ_BYTE;
          plan.psz[1] = SZ_WORD;
          plan.psz[2] = SZ_BYTE;
        end else if (addr_lo[1]) begin
          plan.count  = 2'd2;
          plan.psz[0] = SZ_WORD;
          plan.psz[1] = SZ_WORD;
        end else begin
          plan.psz[0] = SZ_LONG;
        end
      end
      default: begin
        plan.psz[0] = SZ_BYTE;
      end
    endcase
  end
endmodule

// File: rtl/mas_seq.sv
module mas_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       bus_ready,
  input  logic [1:0] count,
  output logic       busy,
  output logic       accept,
  output logic       fire,
  output logic [1:0] idx,
  output logic       done
);
  typedef enum logic {S_IDLE, S_XFER} state_e;

  state_e     state_q, state_n;
  logic [1:0] idx_q, idx_n;
  logic       done_q, done_n;
  logic       last;

  always_comb begin
    state_n = state_q;
    idx_n   = idx_q;
    done_n  = 1'b0;
    accept  = (state_q == S_IDLE) && req_valid;
    fire    = (state_q == S_XFER) && bus_ready;
    last    = (idx_q == (count - 2'd1));
    if (accept) begin
      state_n = S_XFER;
      idx_n   = 2'd0;
    end
    if (fire) begin
      done_n = last;
      if (last) state_n = S_IDLE;
      else      idx_n   = idx_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= 2'd0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
      done_q  <= done_n;
    end
  end

  assign busy = (state_q == S_XFER);
  assign idx  = idx_q;
  assign done = done_q;
endmodule

// File: rtl/mas_lane.sv
module mas_lane
  import mas_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          fire,
  input  logic [DW-1:0] wdata_in,
  input  logic [BW-1:0] op_bytes,
  input  logic [BW-1:0] piece_bytes,
  input  logic [DW-1:0] rdata_in,
  output logic [DW-1:0] piece_wdata,
  output logic [DW-1:0] acc,
  output logic [BW-1:0] offset
);
  logic [DW-1:0] wdata_q, acc_q, acc_n, mask;
  logic [BW-1:0] offset_q, offset_n, rest_bytes;
  logic          wdata_en, acc_en;

  always_comb begin
    if (piece_bytes >= BW'(DW / 8)) mask = '1;
    else mask = (DW'(1) << {piece_bytes, 3'b000}) - DW'(1);
    rest_bytes  = op_bytes - offset_q - piece_bytes;
    piece_wdata = (wdata_q >> {rest_bytes, 3'b000}) & mask;
  end

  always_comb begin
    wdata_en = load;
    acc_en   = load | fire;
    acc_n    = acc_q;
    offset_n = offset_q;
    if (load) begin
      acc_n    = '0;
      offset_n = '0;
    end else if (fire) begin
      acc_n    = (acc_q << {piece_bytes, 3'b000}) | (rdata_in & mask);
      offset_n = offset_q + piece_bytes;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q  <= '0;
      acc_q    <= '0;
      offset_q <= '0;
    end else begin
      if (wdata_en) wdata_q  <= wdata_in;
      if (acc_en)   acc_q    <= acc_n;
      if (acc_en)   offset_q <= offset_n;
    end
  end

  assign acc    = acc_q;
  assign offset = offset_q;
endmodule

// File: rtl/misalign_splitter.sv
module misalign_splitter
  import mas_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_write,
  input  logic [31:0]   req_wdata,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic          bus_write,
  output logic [31:0]   bus_wdata,
  input  logic [31:0]   bus_rdata,
  output logic          done,
  output logic [31:0]   rdata,
  output logic [1:0]    rd_count,
  output logic [1:0]    wr_count
);
  logic          rst_i_n;
  plan_t         plan_in, plan_q;
  logic [AW-1:0] addr_q;
  logic [1:0]    size_q;
  logic          write_q;
  logic [1:0]    rd_q, wr_q;
  logic          busy, accept, fire;
  logic [1:0]    idx;
  logic [1:0]    piece_sz;
  logic [BW-1:0] op_bytes, piece_bytes, offset;
  logic [DW-1:0] piece_wdata, acc;

  mas_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  mas_planner u_plan (
    .addr_lo (req_addr[1:0]),
    .size    (req_size),
    .plan    (plan_in)
  );

  mas_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .req_valid (req_valid),
    .bus_ready (bus_ready),
    .count     (plan_q.count),
    .busy      (busy),
    .accept    (accept),
    .fire      (fire),
    .idx       (idx),
    .done      (done)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      plan_q  <= '0;
      addr_q  <= '0;
      size_q  <= SZ_BYTE;
      write_q <= 1'b0;
      rd_q    <= 2'd0;
      wr_q    <= 2'd0;
    end else if (accept) begin
      plan_q  <= plan_in;
      addr_q  <= req_addr;
      size_q  <= req_size;
      write_q <= req_write;
      rd_q    <= req_write ? 2'd0 : plan_in.count;
      wr_q    <= req_write ? plan_in.count : 2'd0;
    end
  end

  always_comb begin
    piece_sz    = pick_size(plan_q, idx);
    piece_bytes = size_bytes(piece_sz);
    op_bytes    = size_bytes(size_q);
  end

  mas_lane u_lane (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .load        (accept),
    .fire        (fire),
    .wdata_in    (req_wdata),
    .op_bytes    (op_bytes),
    .piece_bytes (piece_bytes),
    .rdata_in    (bus_rdata),
    .piece_wdata (piece_wdata),
    .acc         (acc),
    .offset      (offset)
  );

  assign req_ready = ~busy;
  assign bus_valid = busy;
  assign bus_addr  = addr_q + AW'(offset);
  assign bus_size  = piece_sz;
  assign bus_write = write_q;
  assign bus_wdata = write_q ? piece_wdata : '0;
  assign rdata     = acc;
  assign rd_count  = rd_q;
  assign wr_count  = wr_q;
endmodule

// File: rtl/mas_checker.sv
module mas_checker
  import mas_pkg::*;
#(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          bus_valid,
  input logic          bus_ready,
  input logic [AW-1:0] bus_addr,
  input logic [1:0]    bus_size,
  input logic [31:0]   bus_wdata,
  input logic          done,
  input logic [1:0]    rd_count,
  input logic [1:0]    wr_count
);
  a_r9_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) &&
                                   $stable(bus_size) && $stable(bus_wdata)));

  a_r5_aligned_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> ((bus_size != SZ_WORD || bus_addr[0] == 1'b0) &&
                   (bus_size != SZ_LONG || bus_addr[1:0] == 2'b00)));

  a_r10_not_ready_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> !req_ready);

  a_r10_done_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_one_direction_count: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((rd_count == 2'd0 || wr_count == 2'd0) &&
              (rd_count != 2'd0 || wr_count != 2'd0)));
endmodule

bind misalign_splitter mas_checker #(.AW(AW)) u_mas_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .bus_valid (bus_valid),
  .bus_ready (bus_ready),
  .bus_addr  (bus_addr),
  .bus_size  (bus_size),
  .bus_wdata (bus_wdata),
  .done      (done),
  .rd_count  (rd_count),
  .wr_count  (wr_count)
);

// File: tb/test_misalign_splitter.sv
module test_misalign_splitter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [31:0] req_addr, req_wdata;
  logic [1:0]  req_size;
  logic        bus_valid, bus_ready, bus_write;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0]  bus_size;
  logic        done;
  logic [31:0] rdata;
  logic [1:0]  rd_count, wr_count;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  misalign_splitter #(.AW(32)) i_misalign_splitter (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_write(bus_write), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .done(done), .rdata(rdata),
    .rd_count(rd_count), .wr_count(wr_count)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  size;
    logic        wr;
    logic [31:0] data;
    logic [1:0]  npc;
    logic [5:0]  psz;
    logic [1:0]  stall;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0103, 2'd0, 1'b1, 32'h0000_00A5, 2'd1, 6'b00_00_00, 2'd0},
    '{32'h0000_0200, 2'd1, 1'b0, 32'h0000_1234, 2'd1, 6'b00_00_01, 2'd0},
    '{32'h0000_0201, 2'd1, 1'b1, 32'h0000_BEEF, 2'd2, 6'b00_00_00, 2'd0},
    '{32'h0000_0203, 2'd1, 1'b0, 32'h0000_CAFE, 2'd2, 6'b00_00_00, 2'd1},
    '{32'h0000_0300, 2'd2, 1'b1, 32'h1122_3344, 2'd1, 6'b00_00_10, 2'd0},
    '{32'h0000_0301, 2'd2, 1'b0, 32'hDEAD_BEEF, 2'd3, 6'b00_01_00, 2'd0},
    '{32'h0000_0303, 2'd2, 1'b1, 32'h0102_0304, 2'd3, 6'b00_01_00, 2'd1},
    '{32'h0000_0302, 2'd2, 1'b0, 32'h89AB_CDEF, 2'd2, 6'b00_01_01, 2'd0},
    '{32'h0000_0306, 2'd2, 1'b1, 32'h55AA_6699, 2'd2, 6'b00_01_01, 2'd2},
    '{32'h0000_01FF, 2'd1, 1'b0, 32'h0000_7E81, 2'd2, 6'b00_00_00, 2'd1},
    '{32'h0000_0405, 2'd3, 1'b0, 32'h0000_007E, 2'd1, 6'b00_00_00, 2'd0}
  };

  function automatic int nbytes(input logic [1:0] sz);
    case (sz)
      2'd1:    return 2;
      2'd2:    return 4;
      default: return 1;
    endcase
  endfunction

  function automatic logic [31:0] bmask(input int k);
    if (k >= 4) return 32'hFFFF_FFFF;
    return (32'h1 << (8 * k)) - 32'h1;
  endfunction

  function automatic string shape_tag(input vec_t v);
    if (v.size == 2'd2 && v.addr[0])        return "R3";
    if (v.size == 2'd2 && v.addr[1])        return "R4";
    if (v.size == 2'd1 && v.addr[0])        return "R2";
    if (v.size == 2'd3)                     return "R12";
    return "R1";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge of the done cycle.
  task automatic run(input vec_t v, input bit intrude);
    int total;
    int moved;
    logic [31:0] m;
    logic [31:0] piece;
    string tag;
    total = nbytes(v.size);
    moved = 0;
    tag   = shape_tag(v);
    chk("R10 ready when idle", {31'b0, req_ready}, 32'd1);
    req_valid = 1'b1;
    req_addr  = v.addr;
    req_size  = v.size;
    req_write = v.wr;
    req_wdata = v.data;
    @(negedge clk);
    if (intrude) begin
      req_addr  = 32'h0000_FFF0;
      req_size  = 2'd0;
      req_write = ~v.wr;
      req_wdata = 32'h0BAD_0BAD;
    end else begin
      req_valid = 1'b0;
    end
    for (int p = 0; p < int'(v.npc); p++) begin
      int k;
      k     = nbytes(v.psz[2*p +: 2]);
      m     = bmask(k);
      piece = (v.data >> (8 * (total - moved - k))) & m;
      for (int s = 0; s < int'(v.stall); s++) begin
        bus_ready = 1'b0;
        chk("R9 valid held in stall", {31'b0, bus_valid}, 32'd1);
        chk("R9 addr held in stall", bus_addr, v.addr + 32'(moved));
        @(negedge clk);
      end
      chk("R9 valid", {31'b0, bus_valid}, 32'd1);
      chk({tag, " piece addr"}, bus_addr, v.addr + 32'(moved));
      chk({tag, " piece size"}, {30'b0, bus_size}, {30'b0, v.psz[2*p +: 2]});
      chk("R10 direction", {31'b0, bus_write}, {31'b0, v.wr});
      if (v.wr) chk("R6 store piece", bus_wdata, piece);
      chk("R10 no done mid-sequence", {31'b0, done}, 32'd0);
      if (intrude) chk("R10 busy not ready", {31'b0, req_ready}, 32'd0);
      if (intrude && p == int'(v.npc) - 1) req_valid = 1'b0;
      bus_ready = 1'b1;
      bus_rdata = piece | (32'hF0E1_D2C3 & ~m);
      @(negedge clk);
      bus_ready = 1'b0;
      bus_rdata = 32'h0;
      moved += k;
    end
    chk("R10 done pulse", {31'b0, done}, 32'd1);
    chk("R10 bus idle at done", {31'b0, bus_valid}, 32'd0);
    if (!v.wr) chk("R7 merged load", rdata, v.data & bmask(total));
    chk("R8 rd_count", {30'b0, rd_count}, v.wr ? 32'd0 : {30'b0, v.npc});
    chk("R8 wr_count", {30'b0, wr_count}, v.wr ? {30'b0, v.npc} : 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_addr  = '0;
    req_size  = '0;
    req_write = 1'b0;
    req_wdata = '0;
    bus_ready = 1'b0;
    bus_rdata = '0;
    repeat (3) @(negedge clk);
    chk("R11 valid in reset", {31'b0, bus_valid}, 32'd0);
    chk("R11 done in reset", {31'b0, done}, 32'd0);
    chk("R11 ready in reset", {31'b0, req_ready}, 32'd1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 valid after release", {31'b0, bus_valid}, 32'd0);
    chk("R11 done after release", {31'b0, done}, 32'd0);

    // Back-to-back walk: each request is driven in the previous done cycle.
    for (int i = 0; i < NV; i++) run(VECS[i], 1'b0);

    // Idle gap, then a request held on the inputs during a busy sequence.
    repeat (2) @(negedge clk);
    chk("R10 done clears", {31'b0, done}, 32'd0);
    run(VECS[5], 1'b1);
    @(negedge clk);
    chk("R10 intruder not taken", {31'b0, bus_valid}, 32'd0);
    run(VECS[6], 1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule